// File: doc/BRIEF.md
# Saturating Integer Add/Subtract Unit

This block decodes and executes the saturating add and subtract operations of a 32-bit RISC core. Each operation arrives as one transfer on a valid/ready input channel. The transfer carries a 16-bit instruction halfword, a second halfword for the long-immediate form, and the two register operands that the register file has already read. The block recognises five forms: register add, add with a sign-extended 5-bit immediate, register subtract, reversed-operand subtract, and subtract of a sign-extended 16-bit immediate. When a signed result cannot be represented in 32 bits, the block clamps it to the nearest representable extreme and raises a sticky saturation flag.

Each accepted instruction produces one output transfer one cycle later. The transfer carries the result, a destination write-enable and the destination register index. The flag register changes on that same clock edge.

The output channel follows these back-pressure rules. The output stays valid until `out_ready` is high. While a result is stalled, the result, write-enable and destination stay unchanged, and `in_ready` is low. When the output is empty or is being drained, the block accepts one instruction per cycle.

The flag register can be overwritten through a plain write port. This port is the only way to clear the saturation flag.

Top module: `satu_top`

## Requirements
- R1: After reset, `out_valid` is 0 and all five flags are 0.
- R2: Function code `in_insn[10:5]` = 000110 gives reg2 + reg1. Function code 010001 gives reg2 + sign-extended `in_insn[4:0]`.
- R3: Function code 000101 gives reg2 − reg1. Function code 000100 gives the reversed difference, reg1 − reg2.
- R4: Function code 110011 gives reg1 − sign-extended `in_ext[15:0]`.
- R5: Clamping occurs when the exact signed result exceeds the 32-bit range. A positive overflow yields 0x7FFFFFFF and a negative overflow yields 0x80000000. OV is 1 exactly when clamping occurred.
- R6: The flag vector `flags` has the layout {SAT[4], CY[3], OV[2], S[1], Z[0]}. CY is the unsigned carry of the unclamped add, or the unsigned borrow of the unclamped subtract. S and Z are taken from the clamped result.
- R7: SAT is set when an operation overflows. Operations never clear SAT. A high `flag_wr` loads `flag_wr_val` into the flags, and it takes priority over an operation accepted in the same cycle.
- R8: An instruction with any other function code produces an output transfer with `out_wen` = 0 and `out_result` = 0, and it leaves the flags unchanged.
- R9: `in_ready` = !out_valid || out_ready. A stalled output holds its payload. One instruction is accepted per cycle when the output is free.
- R10: `out_dest` equals `in_insn[15:11]` of the instruction that produced the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction transfer offered |
| in_ready | output | 1 | Instruction transfer accepted when high together with in_valid |
| in_insn | input | 16 | Instruction halfword (dest index, function code, reg1/imm5 field) |
| in_ext | input | 16 | Second halfword, the 16-bit immediate |
| in_reg1 | input | 32 | Value of the register selected by the low field |
| in_reg2 | input | 32 | Value of the destination register |
| out_valid | output | 1 | Result transfer offered |
| out_ready | input | 1 | Consumer takes the result transfer |
| out_result | output | 32 | Clamped result |
| out_wen | output | 1 | Destination write-enable |
| out_dest | output | 5 | Destination register index |
| flag_wr | input | 1 | Load the flag register |
| flag_wr_val | input | 5 | Value loaded by flag_wr |
| flags | output | 5 | {SAT, CY, OV, S, Z} |

## Verification
The assertions check on every cycle the properties that hold regardless of the operand values. These are: SAT stays set unless a flag write occurs; a clamped result is one of the two extremes and leaves SAT set; Z and S agree with the result; an unrecognised function code writes nothing and leaves the flags alone; a stalled output holds and blocks input. The exact arithmetic values can only be shown by the bench's scenarios. These are the sums and differences of each of the five forms, the direction of the reversed subtract, the sign extension of both immediates and the carry/borrow value. The bench also shows the write-over-operation priority on the flag port. It does this by comparing every output against a behavioural model fed with directed boundary operands and random traffic under random back-pressure.

// File: rtl/satu_pkg.sv
package satu_pkg;
  typedef enum logic [2:0] {
    OP_NONE,
    OP_ADD,
    OP_ADDI,
    OP_SUB,
    OP_SUBR,
    OP_SUBI
  } op_e;

  typedef struct packed {
    logic sat;
    logic cy;
    logic ov;
    logic s;
    logic z;
  } flags_t;

  localparam logic [5:0] FN_ADD  = 6'b000110;
  localparam logic [5:0] FN_ADDI = 6'b010001;
  localparam logic [5:0] FN_SUB  = 6'b000101;
  localparam logic [5:0] FN_SUBR = 6'b000100;
  localparam logic [5:0] FN_SUBI = 6'b110011;
endpackage

// File: rtl/satu_decode.sv
module satu_decode
  import satu_pkg::*;
(
  input  logic [5:0] fn,
  output op_e        op,
  output logic       legal
);
  always_comb begin
    case (fn)
      FN_ADD:  op = OP_ADD;
      FN_ADDI: op = OP_ADDI;
      FN_SUB:  op = OP_SUB;
      FN_SUBR: op = OP_SUBR;
      FN_SUBI: op = OP_SUBI;
      default: op = OP_NONE;
    endcase
    legal = (op != OP_NONE);
  end
endmodule

// File: rtl/satu_opsel.sv
module satu_opsel
  import satu_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int SHORT_W = 5,
  parameter int LONG_W  = 16
) (
  input  op_e               op,
  input  logic [SHORT_W-1:0] imm_s,
  input  logic [LONG_W-1:0]  imm_l,
  input  logic [XLEN-1:0]    reg1,
  input  logic [XLEN-1:0]    reg2,
  output logic [XLEN-1:0]    opa,
  output logic [XLEN-1:0]    opb,
  output logic               sub
);
  localparam int PAD_S = XLEN - SHORT_W;
  localparam int PAD_L = XLEN - LONG_W;

  logic [XLEN-1:0] sext_s, sext_l;
  assign sext_s = {{PAD_S{imm_s[SHORT_W-1]}}, imm_s};
  assign sext_l = {{PAD_L{imm_l[LONG_W-1]}}, imm_l};

  always_comb begin
    opa = '0;
    opb = '0;
    sub = 1'b0;
    case (op)
      OP_ADD:  begin opa = reg2; opb = reg1;   end
      OP_ADDI: begin opa = reg2; opb = sext_s; end
      OP_SUB:  begin opa = reg2; opb = reg1;   sub = 1'b1; end
      OP_SUBR: begin opa = reg1; opb = reg2;   sub = 1'b1; end
      OP_SUBI: begin opa = reg1; opb = sext_l; sub = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/satu_addsub.sv
module satu_addsub #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  logic            sub,
  output logic [XLEN-1:0] res,
  output logic            cy,
  output logic            ov
);
  localparam int MSB = XLEN - 1;
  localparam logic [XLEN-1:0] POS_MAX = {1'b0, {(XLEN-1){1'b1}}};
  localparam logic [XLEN-1:0] NEG_MAX = {1'b1, {(XLEN-1){1'b0}}};

  logic [XLEN-1:0] b_eff;
  logic [XLEN:0]   wide;
  logic [XLEN-1:0] raw;

  assign b_eff = sub ? ~opb : opb;
  assign wide  = {1'b0, opa} + {1'b0, b_eff} + {{XLEN{1'b0}}, sub};
  assign raw   = wide[XLEN-1:0];

  always_comb begin
    cy = sub ? ~wide[XLEN] : wide[XLEN];
    ov = ((opa[MSB] ^ opb[MSB]) == sub) && (raw[MSB] != opa[MSB]);
    if (!ov)
      res = raw;
    else if (opa[MSB])
      res = NEG_MAX;
    else
      res = POS_MAX;
  end
endmodule

// File: rtl/satu_top.sv
module satu_top
  import satu_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [15:0]      in_insn,
  input  logic [15:0]      in_ext,
  input  logic [XLEN-1:0]  in_reg1,
  input  logic [XLEN-1:0]  in_reg2,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [XLEN-1:0]  out_result,
  output logic             out_wen,
  output logic [IDX_W-1:0] out_dest,
  input  logic             flag_wr,
  input  logic [4:0]       flag_wr_val,
  output logic [4:0]       flags
);
  localparam int SHORT_W = 5;
  localparam int LONG_W  = 16;

  op_e             op;
  logic            legal;
  logic [XLEN-1:0] opa, opb, res;
  logic            sub, cy, ov, fire;
  flags_t          flg_q, flg_new;

  satu_decode u_dec (
    .fn    (in_insn[10:5]),
    .op    (op),
    .legal (legal)
  );

  satu_opsel #(.XLEN(XLEN), .SHORT_W(SHORT_W), .LONG_W(LONG_W)) u_sel (
    .op    (op),
    .imm_s (in_insn[SHORT_W-1:0]),
    .imm_l (in_ext),
    .reg1  (in_reg1),
    .reg2  (in_reg2),
    .opa   (opa),
    .opb   (opb),
    .sub   (sub)
  );

  satu_addsub #(.XLEN(XLEN)) u_alu (
    .opa (opa),
    .opb (opb),
    .sub (sub),
    .res (res),
    .cy  (cy),
    .ov  (ov)
  );

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  always_comb begin
    flg_new.sat = flg_q.sat | ov;
    flg_new.cy  = cy;
    flg_new.ov  = ov;
    flg_new.s   = res[XLEN-1];
    flg_new.z   = (res == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_wen    <= 1'b0;
      out_dest   <= '0;
    end else if (fire) begin
      out_valid  <= 1'b1;
      out_result <= legal ? res : '0;
      out_wen    <= legal;
      out_dest   <= in_insn[15:11];
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      flg_q <= '0;
    else if (flag_wr)
      flg_q <= flags_t'(flag_wr_val);
    else if (fire && legal)
      flg_q <= flg_new;
  end

  assign flags = flg_q;
endmodule

// File: rtl/satu_chk.sv
module satu_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [15:0]     in_insn,
  input logic            out_valid,
  input logic            out_ready,
  input logic [XLEN-1:0] out_result,
  input logic            out_wen,
  input logic            flag_wr,
  input logic [4:0]      flags
);
  localparam logic [XLEN-1:0] POS_MAX = {1'b0, {(XLEN-1){1'b1}}};
  localparam logic [XLEN-1:0] NEG_MAX = {1'b1, {(XLEN-1){1'b0}}};

  logic known, accept, op_last;
  assign known  = in_insn[10:5] inside {6'b000110, 6'b010001, 6'b000101,
                                        6'b000100, 6'b110011};
  assign accept = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) op_last <= 1'b0;
    else        op_last <= accept && known && !flag_wr;
  end

  AST_UNKNOWN_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !known |=> !out_wen && out_result == '0); // R8
  AST_UNKNOWN_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !known && !flag_wr |=> $stable(flags)); // R8
  AST_CLAMP_EXTREME: assert property (@(posedge clk) disable iff (!rst_n)
    op_last && flags[2] |-> (out_result == POS_MAX || out_result == NEG_MAX)); // R5
  AST_ZERO_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    op_last |-> (flags[0] == (out_result == '0)) && (flags[1] == out_result[XLEN-1])); // R6
  AST_SAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flags[4] && !flag_wr |=> flags[4]); // R7
  AST_OV_SETS_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    op_last && flags[2] |-> flags[4]); // R7
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_wen)); // R9
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R9
endmodule

bind satu_top satu_chk #(.XLEN(XLEN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_insn    (in_insn),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result),
  .out_wen    (out_wen),
  .flag_wr    (flag_wr),
  .flags      (flags)
);

// File: tb/sim_satu_top.sv
`timescale 1ns/1ps
module sim_satu_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_insn = '0;
  logic [15:0] in_ext = '0;
  logic [31:0] in_reg1 = '0;
  logic [31:0] in_reg2 = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  logic        out_wen;
  logic [4:0]  out_dest;
  logic        flag_wr = 1'b0;
  logic [4:0]  flag_wr_val = '0;
  logic [4:0]  flags;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  satu_top u0 (.*);

  // reference model state
  bit        m_valid;
  bit [31:0] m_res;
  bit        m_wen;
  bit [4:0]  m_dest;
  bit [4:0]  m_flags;
  string     m_tag;
  string     m_ftag;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(logic [4:0] dst, logic [5:0] fn, logic [4:0] lo);
    return {dst, fn, lo};
  endfunction

  task automatic compare();
    chk("R9 out_valid", {31'b0, out_valid}, {31'b0, m_valid});
    if (m_valid) begin
      chk(m_tag, out_result, m_res);
      chk("R8 out_wen", {31'b0, out_wen}, {31'b0, m_wen});
      chk("R10 out_dest", {27'b0, out_dest}, {27'b0, m_dest});
    end
    chk(m_ftag, {27'b0, flags}, {27'b0, m_flags});
  endtask

  // one cycle: compare, drive, predict, advance
  task automatic step(bit v, logic [15:0] insn, logic [15:0] ext, logic [31:0] r1,
                      logic [31:0] r2, bit rdy, bit fw, logic [4:0] fwv);
    bit fire, legal, is_sub, ov, cy;
    longint sa, sb, r;
    bit [31:0] ua, ub, res;
    string tag;
    compare();
    in_valid = v; in_insn = insn; in_ext = ext; in_reg1 = r1; in_reg2 = r2;
    out_ready = rdy; flag_wr = fw; flag_wr_val = fwv;
    #0.1;
    chk("R9 in_ready", {31'b0, in_ready}, {31'b0, (!m_valid || rdy)});
    fire = v && (!m_valid || rdy);
    legal = 1; is_sub = 0; sa = 0; sb = 0;
    case (insn[10:5])
      6'b000110: begin sa = longint'($signed(r2)); sb = longint'($signed(r1)); tag = "R2 add"; end
      6'b010001: begin sa = longint'($signed(r2)); sb = longint'($signed(insn[4:0])); tag = "R2 addi"; end
      6'b000101: begin sa = longint'($signed(r2)); sb = longint'($signed(r1)); is_sub = 1; tag = "R3 sub"; end
      6'b000100: begin sa = longint'($signed(r1)); sb = longint'($signed(r2)); is_sub = 1; tag = "R3 subr"; end
      6'b110011: begin sa = longint'($signed(r1)); sb = longint'($signed(ext)); is_sub = 1; tag = "R4 subi"; end
      default:   begin legal = 0; tag = "R8 unknown"; end
    endcase
    ua = sa[31:0]; ub = sb[31:0];
    r = is_sub ? sa - sb : sa + sb;
    cy = is_sub ? (ua < ub) : (({1'b0, ua} + {1'b0, ub}) > 33'h0_FFFF_FFFF);
    ov = (r > 64'sd2147483647) || (r < -64'sd2147483648);
    res = ov ? ((r > 0) ? 32'h7FFF_FFFF : 32'h8000_0000) : r[31:0];
    if (ov) tag = {"R5 ", tag};
    if (fw) begin
      m_flags = fwv; m_ftag = "R7 flag write";
    end else if (fire && legal) begin
      m_flags = {m_flags[4] | ov, cy, ov, res[31], res == 0};
      m_ftag = (ov || m_flags[4]) ? "R7 flags" : "R6 flags";
    end else
      m_ftag = "R8 flags held";
    if (fire) begin
      m_valid = 1; m_res = legal ? res : 0; m_wen = legal; m_dest = insn[15:11]; m_tag = tag;
    end else if (rdy)
      m_valid = 0;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_valid = 0; m_res = 0; m_wen = 0; m_dest = 0; m_flags = 0;
    m_tag = "R1"; m_ftag = "R1 flags";
    repeat (3) @(negedge clk);
    chk("R1 reset valid", {31'b0, out_valid}, 32'd0);
    chk("R1 reset flags", {27'b0, flags}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 plain and immediate adds
    step(1, mk(5'd3, 6'b000110, 5'd1), 0, 32'd2, 32'd1, 1, 0, 0);
    step(1, mk(5'd4, 6'b010001, 5'h1F), 0, 0, 32'd1, 1, 0, 0);        // 1 + (-1) = 0, Z
    step(1, mk(5'd5, 6'b010001, 5'h10), 0, 0, 32'd5, 1, 0, 0);        // 5 + (-16)
    // R5 positive / negative clamp
    step(1, mk(5'd6, 6'b000110, 5'd2), 0, 32'd1, 32'h7FFF_FFFF, 1, 0, 0);
    step(1, mk(5'd7, 6'b000110, 5'd2), 0, 32'hFFFF_FFFF, 32'h8000_0000, 1, 0, 0);
    // R7 SAT stays while plain ops run, cleared only by write
    step(1, mk(5'd8, 6'b000110, 5'd2), 0, 32'd1, 32'd1, 1, 0, 0);
    step(0, 0, 0, 0, 0, 1, 1, 5'b00000);
    // R3 subtract and reversed subtract, borrow
    step(1, mk(5'd9, 6'b000101, 5'd1), 0, 32'd1, 32'd0, 1, 0, 0);
    step(1, mk(5'd9, 6'b000100, 5'd1), 0, 32'd10, 32'd3, 1, 0, 0);
    step(1, mk(5'd9, 6'b000101, 5'd1), 0, 32'h7FFF_FFFF, 32'h8000_0000, 1, 0, 0);
    // R4 long immediate subtract
    step(1, mk(5'd10, 6'b110011, 5'd1), 16'h8000, 32'h7FFF_FFFF, 0, 1, 0, 0);
    step(1, mk(5'd11, 6'b110011, 5'd1), 16'h0005, 32'd3, 0, 1, 0, 0);
    // R8 unknown code, R7 write priority over same-cycle op
    step(1, mk(5'd12, 6'b111111, 5'd1), 0, 32'd1, 32'd1, 1, 0, 0);
    step(1, mk(5'd13, 6'b000110, 5'd1), 0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1, 1, 5'b01010);
    // R9 back-pressure
    step(1, mk(5'd14, 6'b000110, 5'd1), 0, 32'd4, 32'd4, 0, 0, 0);
    step(1, mk(5'd15, 6'b000101, 5'd1), 0, 32'd9, 32'd9, 0, 0, 0);
    step(1, mk(5'd15, 6'b000101, 5'd1), 0, 32'd9, 32'd9, 1, 0, 0);
    step(0, 0, 0, 0, 0, 1, 0, 0);
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [5:0] fn;
      logic [31:0] a, b;
      int k;
      k = $urandom_range(0, 6);
      case (k)
        0: fn = 6'b000110; 1: fn = 6'b010001; 2: fn = 6'b000101;
        3: fn = 6'b000100; 4: fn = 6'b110011; default: fn = 6'($urandom);
      endcase
      a = ($urandom_range(0, 3) == 0) ? {$urandom_range(0, 1) == 1, 31'h7FFF_FFFF} : $urandom;
      b = ($urandom_range(0, 3) == 0) ? {$urandom_range(0, 1) == 1, 31'h0} : $urandom;
      step($urandom_range(0, 3) != 0, mk(5'($urandom), fn, 5'($urandom)), 16'($urandom),
           a, b, $urandom_range(0, 3) != 0, $urandom_range(0, 40) == 0, 5'($urandom));
    end
    compare();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule